// File: doc/BRIEF.md
# Four-Lane ChaCha20 Keystream Block Engine

This block turns a 256-bit key, a 96-bit nonce and a 32-bit block counter into one 512-bit ChaCha20 keystream block. The working state is held as four rows of four 32-bit words. Four quarter-round units work side by side, one per lane, so all four columns are mixed at the same time.

The diagonal half of each double round reuses the same four units. Before it, rows 1, 2 and 3 are rotated across the lanes, and after it they are rotated back. One double round is completed per clock cycle.

A caller pulses `start` while the engine is idle. It then waits for the one-cycle `done` pulse and takes the 64-byte keystream from `keystream`. Sequencing the counter across blocks and combining the keystream with data are left to the caller.

Top module: `chacha_lane_core`

## Requirements
- R1: While `rst_n` is low and after its release, `busy` and `done` are 0 and `keystream` is all zeros until the first block completes.
- R2: A `start` sampled high while `busy` is low makes `busy` high from the next cycle. `done` rises exactly 11 clock edges after the accepting edge, in the same cycle that `busy` falls.
- R3: `done` is high for exactly one cycle per block.
- R4: A `start` pulse, or any change of `key`, `nonce` or `counter`, while `busy` is high has no effect: the running block completes on time, and its keystream comes only from the inputs sampled at the accepting edge.
- R5: The initial state is laid out as four rows. Words 0..3 are 0x61707865, 0x3320646e, 0x79622d32 and 0x6b206574. Words 4..11 are `key[32j+31:32j]` for j = 0..7, with key byte i at `key[8i+7:8i]`. Word 12 is `counter`. Words 13..15 are `nonce[32j+31:32j]` for j = 0..2.
- R6: Each block runs 10 double rounds. Each double round is a column pass over word groups {0,4,8,12}, {1,5,9,13}, {2,6,10,14} and {3,7,11,15}, followed by a diagonal pass over {0,5,10,15}, {1,6,11,12}, {2,7,8,13} and {3,4,9,14}. Each group is processed by the quarter round: add/xor/rotate by 16, 12, 8 and 7, with additions modulo 2^32.
- R7: After the last double round, each word is added modulo 2^32 to its initial value.
- R8: Output word w occupies `keystream[32w+31:32w]`, so keystream byte k is `keystream[8k+7:8k]`, little-endian within each word.
- R9: For key bytes 0x00..0x1f, nonce bytes 00 00 00 09 00 00 00 4a 00 00 00 00 and counter 1, the first keystream byte is 0x10 and the last is 0x4e, matching the published test block.
- R10: `keystream` holds its value in every cycle in which `done` is low.
- R11: A `start` sampled in the same cycle as `done` is accepted and begins a new block without a gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Request a block; sampled only while idle |
| key | input | 256 | Key, byte i at bits 8i+7:8i |
| nonce | input | 96 | Nonce, byte i at bits 8i+7:8i |
| counter | input | 32 | Block counter word |
| busy | output | 1 | High while a block is in progress |
| done | output | 1 | One-cycle pulse when `keystream` is updated |
| keystream | output | 512 | 64-byte keystream block, byte k at bits 8k+7:8k |

## Verification
After an accepting edge, `busy` is due one edge later. `done` and the new `keystream` are due exactly 11 edges later, and `keystream` then stays unchanged until the next `done`. The bench keeps a model that steps once per clock edge with the same acceptance rule. It compares `busy`, `done` and `keystream` with that model at every falling edge, half a period after the outputs were updated. The model computes each expected block from a scalar, index-addressed quarter-round sequence.

// File: rtl/chacha_lane_pkg.sv
package chacha_lane_pkg;

  localparam int CL_WORD_W  = 32;
  localparam int CL_LANES   = 4;
  localparam int CL_ROWS    = 4;
  localparam int CL_KEY_WORDS   = 8;
  localparam int CL_NONCE_WORDS = 3;
  localparam int CL_KEY_W   = CL_KEY_WORDS * CL_WORD_W;
  localparam int CL_NONCE_W = CL_NONCE_WORDS * CL_WORD_W;
  localparam int CL_CTR_W   = CL_WORD_W;
  localparam int CL_BLOCK_W = CL_ROWS * CL_LANES * CL_WORD_W;

  // rotate amounts of the four mixing steps
  localparam int CL_ROT_A = 16;
  localparam int CL_ROT_B = 12;
  localparam int CL_ROT_C = 8;
  localparam int CL_ROT_D = 7;

  typedef logic [CL_WORD_W-1:0] cl_word_t;
  typedef cl_word_t [CL_LANES-1:0] cl_row_t;
  typedef cl_row_t  [CL_ROWS-1:0]  cl_mat_t;

  // row 0 constant words, lane 0 in the least significant slot
  localparam cl_row_t CL_SIGMA = {32'h6b206574, 32'h79622d32,
                                  32'h3320646e, 32'h61707865};

  typedef enum logic [1:0] {
    CL_IDLE  = 2'd0,
    CL_RUN   = 2'd1,
    CL_FINAL = 2'd2
  } cl_phase_e;

  function automatic cl_word_t cl_rotl(input cl_word_t x, input int unsigned n);
    return (x << n) | (x >> (CL_WORD_W - n));
  endfunction

endpackage

// File: rtl/cl_quarter_round.sv
module cl_quarter_round
  import chacha_lane_pkg::*;
(
  input  cl_word_t a_i,
  input  cl_word_t b_i,
  input  cl_word_t c_i,
  input  cl_word_t d_i,
  output cl_word_t a_o,
  output cl_word_t b_o,
  output cl_word_t c_o,
  output cl_word_t d_o
);

  cl_word_t a1, b1, c1, d1;
  cl_word_t a2, b2, c2, d2;

  always_comb begin
    a1 = a_i + b_i;
    d1 = cl_rotl(d_i ^ a1, CL_ROT_A);
    c1 = c_i + d1;
    b1 = cl_rotl(b_i ^ c1, CL_ROT_B);
    a2 = a1 + b1;
    d2 = cl_rotl(d1 ^ a2, CL_ROT_C);
    c2 = c1 + d2;
    b2 = cl_rotl(b1 ^ c2, CL_ROT_D);
  end

  assign a_o = a2;
  assign b_o = b2;
  assign c_o = c2;
  assign d_o = d2;

endmodule

// File: rtl/cl_state_loader.sv
module cl_state_loader
  import chacha_lane_pkg::*;
(
  input  logic [CL_KEY_W-1:0]   key_i,
  input  logic [CL_NONCE_W-1:0] nonce_i,
  input  logic [CL_CTR_W-1:0]   ctr_i,
  output cl_mat_t               mat_o
);

  // row 0: constants; rows 1-2: key words; row 3: counter then nonce
  assign mat_o[0] = CL_SIGMA;

  for (genvar j = 0; j < CL_KEY_WORDS; j++) begin : g_key
    assign mat_o[1 + j / CL_LANES][j % CL_LANES] = key_i[CL_WORD_W*j +: CL_WORD_W];
  end

  assign mat_o[CL_ROWS-1][0] = ctr_i;

  for (genvar j = 0; j < CL_NONCE_WORDS; j++) begin : g_nonce
    assign mat_o[CL_ROWS-1][1 + j] = nonce_i[CL_WORD_W*j +: CL_WORD_W];
  end

endmodule

// File: rtl/cl_double_round.sv
module cl_double_round
  import chacha_lane_pkg::*;
(
  input  cl_mat_t s_i,
  output cl_mat_t s_o
);

  cl_mat_t col_q;   // after the column pass
  cl_mat_t diag_in; // rows shifted left by their row index
  cl_mat_t diag_q;  // after the diagonal pass

  for (genvar l = 0; l < CL_LANES; l++) begin : g_col
    cl_quarter_round u_qr_col (
      .a_i (s_i[0][l]),   .b_i (s_i[1][l]),
      .c_i (s_i[2][l]),   .d_i (s_i[3][l]),
      .a_o (col_q[0][l]), .b_o (col_q[1][l]),
      .c_o (col_q[2][l]), .d_o (col_q[3][l])
    );
  end

  // lane l of row r picks lane (l + r) mod 4, so each lane sees a diagonal
  for (genvar r = 0; r < CL_ROWS; r++) begin : g_shl_r
    for (genvar l = 0; l < CL_LANES; l++) begin : g_shl_l
      assign diag_in[r][l] = col_q[r][(l + r) % CL_LANES];
    end
  end

  for (genvar l = 0; l < CL_LANES; l++) begin : g_diag
    cl_quarter_round u_qr_diag (
      .a_i (diag_in[0][l]), .b_i (diag_in[1][l]),
      .c_i (diag_in[2][l]), .d_i (diag_in[3][l]),
      .a_o (diag_q[0][l]),  .b_o (diag_q[1][l]),
      .c_o (diag_q[2][l]),  .d_o (diag_q[3][l])
    );
  end

  // inverse shift puts every word back at its home lane
  for (genvar r = 0; r < CL_ROWS; r++) begin : g_shr_r
    for (genvar l = 0; l < CL_LANES; l++) begin : g_shr_l
      assign s_o[r][l] = diag_q[r][(l + CL_LANES - r) % CL_LANES];
    end
  end

endmodule

// File: rtl/chacha_lane_core.sv
module chacha_lane_core
  import chacha_lane_pkg::*;
#(
  parameter int DOUBLE_ROUNDS = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [CL_KEY_W-1:0]   key,
  input  logic [CL_NONCE_W-1:0] nonce,
  input  logic [CL_CTR_W-1:0]   counter,
  output logic                  busy,
  output logic                  done,
  output logic [CL_BLOCK_W-1:0] keystream
);

  localparam int RND_W = $clog2(DOUBLE_ROUNDS + 1);
  localparam logic [RND_W-1:0] RND_LAST = RND_W'(DOUBLE_ROUNDS - 1);

  cl_phase_e phase_q, phase_d;
  cl_mat_t   state_q, state_d, init_q, load_mat, round_out;
  logic      state_en, init_en, rnd_en, ks_en;
  logic [RND_W-1:0] rnd_q, rnd_d;
  logic      done_q, done_d;
  logic [CL_BLOCK_W-1:0] ks_q, ks_d;

  cl_state_loader u_load (
    .key_i   (key),
    .nonce_i (nonce),
    .ctr_i   (counter),
    .mat_o   (load_mat)
  );

  cl_double_round u_round (
    .s_i (state_q),
    .s_o (round_out)
  );

  // feed-forward sum, serialised word by word in row-major order
  for (genvar r = 0; r < CL_ROWS; r++) begin : g_sum_r
    for (genvar l = 0; l < CL_LANES; l++) begin : g_sum_l
      assign ks_d[CL_WORD_W*(CL_LANES*r + l) +: CL_WORD_W] = state_q[r][l] + init_q[r][l];
    end
  end

  always_comb begin
    phase_d  = phase_q;
    state_d  = state_q;
    state_en = 1'b0;
    init_en  = 1'b0;
    rnd_d    = rnd_q;
    rnd_en   = 1'b0;
    ks_en    = 1'b0;
    done_d   = 1'b0;
    case (phase_q)
      CL_IDLE: begin
        if (start) begin
          phase_d  = CL_RUN;
          state_d  = load_mat;
          state_en = 1'b1;
          init_en  = 1'b1;
          rnd_d    = '0;
          rnd_en   = 1'b1;
        end
      end
      CL_RUN: begin
        state_d  = round_out;
        state_en = 1'b1;
        rnd_d    = rnd_q + 1'b1;
        rnd_en   = 1'b1;
        if (rnd_q == RND_LAST) begin
          phase_d = CL_FINAL;
        end
      end
      CL_FINAL: begin
        ks_en   = 1'b1;
        done_d  = 1'b1;
        phase_d = CL_IDLE;
      end
      default: phase_d = CL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= CL_IDLE;
      rnd_q   <= '0;
      done_q  <= 1'b0;
      state_q <= '0;
      init_q  <= '0;
      ks_q    <= '0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
      if (rnd_en)   rnd_q   <= rnd_d;
      if (state_en) state_q <= state_d;
      if (init_en)  init_q  <= load_mat;
      if (ks_en)    ks_q    <= ks_d;
    end
  end

  assign busy      = (phase_q != CL_IDLE);
  assign done      = done_q;
  assign keystream = ks_q;

endmodule

// File: rtl/chacha_lane_chk.sv
module chacha_lane_chk
  import chacha_lane_pkg::*;
#(
  parameter int DOUBLE_ROUNDS = 10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic                  busy,
  input logic                  done,
  input logic [CL_BLOCK_W-1:0] keystream
);

  localparam int LAT   = DOUBLE_ROUNDS + 1;
  localparam int CNT_W = $clog2(LAT + 3);

  // edges seen since the accepting edge, counted independently of the core
  logic [CNT_W-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (start && !busy) begin
      lat_q <= CNT_W'(1);
    end else if (busy) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);                                  // R2

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == CNT_W'(LAT + 1)));                        // R2

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                             // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                             // R3

  AST_KS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(keystream));                               // R10

endmodule

bind chacha_lane_core chacha_lane_chk #(.DOUBLE_ROUNDS(DOUBLE_ROUNDS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .keystream (keystream)
);

// File: tb/sim_chacha_lane_core.sv
module sim_chacha_lane_core;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;
  localparam int LAT        = 11;

  localparam logic [511:0] KAT_BLOCK = {
    32'h4e3c50a2, 32'he883d0cb, 32'hb94e16de, 32'hd19c12b5,
    32'ha2028bd9, 32'h05d7c214, 32'h09aa9f07, 32'h466482d2,
    32'h4e6cd4c3, 32'h9aaa2204, 32'h0368c033, 32'hc7f4d1c7,
    32'hc47120a3, 32'h1fdd0f50, 32'h15593bd1, 32'he4e7f110};

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [255:0] key;
  logic [95:0]  nonce;
  logic [31:0]  counter;
  logic         busy;
  logic         done;
  logic [511:0] keystream;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  // behavioural model state
  bit           m_busy = 0;
  bit           m_done = 0;
  int           m_cnt  = 0;
  logic [511:0] m_ks   = '0;
  logic [511:0] m_exp  = '0;

  chacha_lane_core u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .key       (key),
    .nonce     (nonce),
    .counter   (counter),
    .busy      (busy),
    .done      (done),
    .keystream (keystream)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  function automatic bit [31:0] rol32(input bit [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic void qr(inout bit [31:0] x[16], input int a, input int b,
                             input int c, input int d);
    x[a] = x[a] + x[b]; x[d] = rol32(x[d] ^ x[a], 16);
    x[c] = x[c] + x[d]; x[b] = rol32(x[b] ^ x[c], 12);
    x[a] = x[a] + x[b]; x[d] = rol32(x[d] ^ x[a], 8);
    x[c] = x[c] + x[d]; x[b] = rol32(x[b] ^ x[c], 7);
  endfunction

  // scalar, index-addressed reference of one block (R5, R6, R7, R8)
  function automatic logic [511:0] ref_block(input logic [255:0] k,
                                             input logic [95:0] n,
                                             input logic [31:0] c);
    bit [31:0] s[16];
    bit [31:0] x[16];
    logic [511:0] r;
    s[0] = 32'h61707865; s[1] = 32'h3320646e;
    s[2] = 32'h79622d32; s[3] = 32'h6b206574;
    for (int i = 0; i < 8; i++) s[4 + i] = k[32*i +: 32];
    s[12] = c;
    for (int i = 0; i < 3; i++) s[13 + i] = n[32*i +: 32];
    x = s;
    for (int i = 0; i < 10; i++) begin
      qr(x, 0, 4, 8, 12); qr(x, 1, 5, 9, 13); qr(x, 2, 6, 10, 14); qr(x, 3, 7, 11, 15);
      qr(x, 0, 5, 10, 15); qr(x, 1, 6, 11, 12); qr(x, 2, 7, 8, 13); qr(x, 3, 4, 9, 14);
    end
    for (int i = 0; i < 16; i++) r[32*i +: 32] = x[i] + s[i];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [511:0] act,
                       input logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // one clock: compare outputs with the model, drive inputs, advance the model
  task automatic step(input bit st, input logic [255:0] k, input logic [95:0] n,
                      input logic [31:0] c);
    bit nd;
    @(negedge clk);
    check(busy === m_busy, "R2 busy", 512'(busy), 512'(m_busy));
    check(done === m_done, "R3 done", 512'(done), 512'(m_done));
    check(keystream === m_ks, "R6/R7/R10 keystream", keystream, m_ks);
    start = st; key = k; nonce = n; counter = c;
    nd = 0;
    if (st && !m_busy) begin
      m_busy = 1; m_cnt = 0; m_exp = ref_block(k, n, c);
    end else if (m_busy) begin
      m_cnt++;
      if (m_cnt == LAT) begin
        m_busy = 0; nd = 1; m_ks = m_exp;
      end
    end
    m_done = nd;
  endtask

  task automatic idle_step();
    step(1'b0, {8{$urandom}}, {3{$urandom}}, $urandom);
  endtask

  // accept a block, optionally disturbing start and inputs while busy (R4)
  task automatic run_block(input logic [255:0] k, input logic [95:0] n,
                           input logic [31:0] c, input bit noise);
    step(1'b1, k, n, c);
    for (int i = 1; i <= LAT + 1; i++) begin
      step(noise && (i <= LAT - 1) && ($urandom % 2 == 0),
           {8{$urandom}}, {3{$urandom}}, $urandom);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_fail++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    logic [255:0] kat_key;
    logic [255:0] ka;
    logic [95:0]  na;
    logic [31:0]  ca;
    rst_n = 1'b0; start = 1'b0; key = '0; nonce = '0; counter = '0;
    for (int i = 0; i < 32; i++) kat_key[8*i +: 8] = 8'(i);

    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      check(busy === 1'b0 && done === 1'b0, "R1 flags in reset", 512'({busy, done}), '0);
      check(keystream === '0, "R1 keystream in reset", keystream, '0);
    end
    rst_n = 1'b1;
    repeat (2) idle_step();

    // R9, R5, R8: published test block
    run_block(kat_key, {32'h0, 32'h4a000000, 32'h09000000}, 32'd1, 1'b0);
    check(keystream === KAT_BLOCK, "R5/R9 test block", keystream, KAT_BLOCK);
    check(keystream[7:0] === 8'h10 && keystream[511:504] === 8'h4e,
          "R8 byte order", {keystream[511:504], keystream[7:0]}, 512'h4e10);

    // R6/R7: random inputs against the scalar reference
    for (int b = 0; b < 12; b++) begin
      ka = {8{$urandom}}; na = {3{$urandom}}; ca = $urandom;
      run_block(ka, na, ca, 1'b0);
      check(keystream === ref_block(ka, na, ca), "R6/R7 random block", keystream,
            ref_block(ka, na, ca));
      repeat (b % 3) idle_step();
    end

    // R4: start and input changes during a block are ignored
    for (int b = 0; b < 6; b++) begin
      ka = {8{$urandom}}; na = {3{$urandom}}; ca = $urandom;
      run_block(ka, na, ca, 1'b1);
      check(keystream === ref_block(ka, na, ca), "R4 inputs while busy", keystream,
            ref_block(ka, na, ca));
    end

    // R7: wrap-around in every addition path
    run_block({256{1'b1}}, {96{1'b1}}, 32'hffffffff, 1'b0);
    check(keystream === ref_block({256{1'b1}}, {96{1'b1}}, 32'hffffffff),
          "R7 all-ones inputs", keystream, ref_block({256{1'b1}}, {96{1'b1}}, 32'hffffffff));
    run_block('0, '0, 32'h0, 1'b0);
    check(keystream === ref_block('0, '0, 32'h0), "R7 all-zero inputs", keystream,
          ref_block('0, '0, 32'h0));

    // R11: second start in the done cycle
    ka = {8{$urandom}}; na = {3{$urandom}}; ca = $urandom;
    step(1'b1, {8{$urandom}}, {3{$urandom}}, $urandom);
    for (int i = 1; i <= LAT; i++) idle_step();
    step(1'b1, ka, na, ca);
    for (int i = 1; i <= LAT + 1; i++) idle_step();
    check(keystream === ref_block(ka, na, ca), "R11 back-to-back block", keystream,
          ref_block(ka, na, ca));

    repeat (3) idle_step();
    summary();
    $finish;
  end

endmodule